// File: doc/BRIEF.md
# Systolic FIR Filter with Symmetric Output Rounding

This block is a finite impulse response filter built as a chain of identical multiply-accumulate stages. A sample enters the first stage, walks down a two-register-per-stage delay line, and each stage adds its registered product to the registered partial sum handed on by the stage before it. The input, the coefficients and the output are all signed fixed-point words of `N` bits with `L` fractional bits. The coefficients are constants chosen at elaboration from the tap count `M`: one set of 12 taps and one set of 24 taps. Products and partial sums keep full precision. A single quantizer at the end of the chain rounds the sum to `L` fractional bits, with ties rounded away from zero, and saturates the result to `N` bits.

Samples arrive and leave on valid/ready streams. The whole pipeline advances by one step only when an input sample is accepted, so gaps in the input never break the alignment of the delay line and the partial sums. Each accepted sample loads one result into the output register. That result belongs to the sample accepted `M+3` acceptances earlier. While the output register holds a result that the consumer has not taken, `in_ready` stays low and nothing inside moves.

Top module: `fir_systolic`

## Requirements
- R1: `rst` is active high and sampled on the clock. It clears every pipeline register, `y_out` and `out_valid`, so `in_ready` is 1 after reset and the first `M+3` results after reset are 0.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Each acceptance sets `out_valid` in the next cycle. Counting acceptances from 0 after reset, the result loaded by acceptance t is the filter output for sample t-(M+3), or 0 when that index is negative.
- R3: The filter output for sample t is the exact sum over j = 0..M-1 of h[j]·x[t-j], with 2L fractional bits and no rounding before the final stage. Samples before reset count as 0.
- R4: The final stage rounds to L fractional bits with ties away from zero. A sum of +0.5 LSB gives +1 LSB, and a sum of -0.5 LSB gives -1 LSB.
- R5: The rounded value is saturated to the range -2^(N-1) .. 2^(N-1)-1.
- R6: The coefficients are defined in signed Q1.15. For M=12, h = -210, -480, 350, 2400, 5600, 8200, 8200, 5600, 2400, 350, -480, -210. For M=24, the first twelve are -61, -131, -159, -41, 251, 561, 579, 121, -781, -1239, 1501, 12001, and tap j for j ≥ 12 equals tap 23-j. For L ≥ 15 a value is scaled up by 2^(L-15). For L < 15 it is scaled down by floor((c + 2^(14-L)) / 2^(15-L)).
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, `out_valid` and `y_out` hold, and no sample is taken (the value on `x_in` is ignored).
- R8: In a cycle with no acceptance and `out_ready` at 1, `out_valid` falls at the next edge and `y_out` holds. The filter state is unchanged, so the stream continues after the gap as if there had been none.
- R9: `in_ready` is 1 in the same cycle whenever `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| x_in | input | N | Input sample, signed, L fractional bits |
| out_valid | output | 1 | `y_out` holds a result not yet taken |
| out_ready | input | 1 | Consumer takes the result this cycle |
| y_out | output | N | Filtered sample, signed, L fractional bits |

## Verification
The bench builds two instances side by side and drives them with the same stream and the same handshake. One instance uses the defaults (N=12, L=11, M=12). The other uses N=16, L=15, M=24, fed the same values scaled by 16. Between them, both coefficient sets are covered, as well as both ways of rescaling a coefficient (rounded down-scaling and exact shift) and two different pipeline latencies. An impulse of ±0.5 lands exactly on rounding ties for the odd-valued coefficients of both configurations. Sign-matched full-scale patterns drive the 12-tap instance into both saturation limits.

// File: rtl/fir_sys_pkg.sv
package fir_sys_pkg;

  localparam int SRC_FRAC = 15;

  localparam int TAB_SHORT [12] = '{-210, -480, 350, 2400, 5600, 8200,
                                    8200, 5600, 2400, 350, -480, -210};
  localparam int TAB_LONG_HALF [12] = '{-61, -131, -159, -41, 251, 561,
                                        579, 121, -781, -1239, 1501, 12001};

  // Q1.15 base value of tap k for a filter of m taps
  function automatic longint base_coef(int m, int k);
    if (m == 24)
      return longint'((k < 12) ? TAB_LONG_HALF[k] : TAB_LONG_HALF[23 - k]);
    else
      return longint'(TAB_SHORT[k % 12]);
  endfunction

  // Tap value rescaled to frac_bits fractional bits
  function automatic longint scaled_coef(int m, int frac_bits, int k);
    longint c;
    c = base_coef(m, k);
    if (frac_bits >= SRC_FRAC)
      return c <<< (frac_bits - SRC_FRAC);
    else
      return (c + (longint'(1) <<< (SRC_FRAC - 1 - frac_bits))) >>> (SRC_FRAC - frac_bits);
  endfunction

endpackage

// File: rtl/fir_tap.sv
module fir_tap #(
  parameter int N  = 12,
  parameter int AW = 28,
  parameter logic signed [N-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [N-1:0]  x_in,
  output logic signed [N-1:0]  x_out,
  input  logic signed [AW-1:0] sum_in,
  output logic signed [AW-1:0] sum_out
);
  localparam int PW = 2 * N;
  localparam logic signed [PW-1:0] COEF_W = {{N{COEF[N-1]}}, COEF};

  logic signed [N-1:0]  x_a, x_b;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] x_b_w;
  logic signed [AW-1:0] acc;

  assign x_b_w = {{N{x_b[N-1]}}, x_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      x_a  <= '0;
      x_b  <= '0;
      prod <= '0;
      acc  <= '0;
    end else if (en) begin
      x_a  <= x_in;
      x_b  <= x_a;
      prod <= x_b_w * COEF_W;
      acc  <= sum_in + {{(AW-PW){prod[PW-1]}}, prod};
    end
  end

  assign x_out   = x_b;
  assign sum_out = acc;
endmodule

// File: rtl/fir_quant.sv
module fir_quant #(
  parameter int N  = 12,
  parameter int L  = 11,
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [AW-1:0] acc_in,
  output logic signed [N-1:0]  y_q
);
  localparam int SW = AW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(longint'(1) <<< (L - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((longint'(1) <<< (N - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = SW'(-(longint'(1) <<< (N - 1)));

  logic signed [SW-1:0] ext, biased, shr;
  logic signed [N-1:0]  sat;

  // bias by half an LSB, one less for negatives, then floor: ties leave zero
  always_comb begin
    ext    = {acc_in[AW-1], acc_in};
    biased = ext + HALF - {{(SW-1){1'b0}}, acc_in[AW-1]};
    shr    = biased >>> L;
    if (shr > MAXV)      sat = MAXV[N-1:0];
    else if (shr < MINV) sat = MINV[N-1:0];
    else                 sat = shr[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     y_q <= '0;
    else if (en) y_q <= sat;
  end
endmodule

// File: rtl/fir_systolic.sv
module fir_systolic #(
  parameter int N = 12,
  parameter int L = 11,
  parameter int M = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] x_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] y_out
);
  localparam int AW = 2 * N + $clog2(M);

  logic                 step;
  logic                 ov_q;
  logic signed [N-1:0]  x_chain [M+1];
  logic signed [AW-1:0] s_chain [M+1];
  logic signed [AW-1:0] sum_last;
  logic signed [N-1:0]  y_q;

  assign in_ready   = !ov_q || out_ready;
  assign step       = in_valid && in_ready;
  assign x_chain[0] = x_in;
  assign s_chain[0] = '0;
  assign sum_last   = s_chain[M];

  for (genvar k = 0; k < M; k++) begin : g_tap
    fir_tap #(
      .N   (N),
      .AW  (AW),
      .COEF(N'(fir_sys_pkg::scaled_coef(M, L, k)))
    ) u_tap (
      .clk    (clk),
      .rst    (rst),
      .en     (step),
      .x_in   (x_chain[k]),
      .x_out  (x_chain[k+1]),
      .sum_in (s_chain[k]),
      .sum_out(s_chain[k+1])
    );
  end

  fir_quant #(.N(N), .L(L), .AW(AW)) u_quant (
    .clk   (clk),
    .rst   (rst),
    .en    (step),
    .acc_in(sum_last),
    .y_q   (y_q)
  );

  always_ff @(posedge clk) begin
    if (rst)            ov_q <= 1'b0;
    else if (step)      ov_q <= 1'b1;
    else if (out_ready) ov_q <= 1'b0;
  end

  assign out_valid = ov_q;
  assign y_out     = y_q;
endmodule

// File: rtl/fir_systolic_chk.sv
module fir_systolic_chk #(
  parameter int N  = 12,
  parameter int AW = 28
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [N-1:0]  y_out,
  input logic [AW-1:0] sum_last
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && y_out == '0));

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(y_out)));

  assert_state_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(sum_last));

  assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && out_ready) |=> (!out_valid && $stable(y_out)));
endmodule

bind fir_systolic fir_systolic_chk #(.N(N), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .y_out    (y_out),
  .sum_last (sum_last)
);

// File: tb/sim_fir_systolic.sv
module sim_fir_systolic;
  localparam int CLK_PERIOD = 10;
  localparam int DS = 15;   // latency in acceptances, 12 taps
  localparam int DL = 27;   // latency in acceptances, 24 taps

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [11:0] xs = '0;
  logic [15:0] xl = '0;
  logic rdy_s, rdy_l, ov_s, ov_l;
  logic [11:0] ys;
  logic [15:0] yl;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_systolic u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_s), .x_in(xs),
    .out_valid(ov_s), .out_ready(out_ready), .y_out(ys));

  fir_systolic #(.N(16), .L(15), .M(24)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_l), .x_in(xl),
    .out_valid(ov_l), .out_ready(out_ready), .y_out(yl));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int n = 0;
  int hist_s [0:1023];
  int hist_l [0:1023];
  int last_s, last_l;
  bit seen_max, seen_min;
  int lfsr = 32'h1ACE_5EED;

  localparam int TS [12] = '{-210, -480, 350, 2400, 5600, 8200,
                             8200, 5600, 2400, 350, -480, -210};
  localparam int TL [12] = '{-61, -131, -159, -41, 251, 561,
                             579, 121, -781, -1239, 1501, 12001};

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6: coefficients in the output format of each instance
  function automatic int coef(bit lg, int j);
    int c;
    if (lg) return (j < 12) ? TL[j] : TL[23 - j];
    c = TS[j];
    return (c + 8) >>> 4;
  endfunction

  // R3, R4, R5: exact convolution, ties away from zero, clamp
  function automatic int ref_y(bit lg, int t);
    int m, l, w;
    longint acc, q, lim, h;
    if (t < 0) return 0;
    m = lg ? 24 : 12;
    l = lg ? 15 : 11;
    w = lg ? 16 : 12;
    acc = 0;
    for (int j = 0; j < m; j++)
      if (t - j >= 0)
        acc += longint'(coef(lg, j)) * longint'(lg ? hist_l[t-j] : hist_s[t-j]);
    h = longint'(1) <<< (l - 1);
    if (acc >= 0) q = (acc + h) >>> l;
    else          q = -((-acc + h) >>> l);
    lim = longint'(1) <<< (w - 1);
    if (q > lim - 1) q = lim - 1;
    if (q < -lim)    q = -lim;
    return int'(q);
  endfunction

  // one accepted sample on both instances, then compare both results (R2)
  task automatic push(int v);
    int es, el;
    in_valid = 1'b1;
    xs = 12'(v);
    xl = 16'(v * 16);
    while (!rdy_s) @(negedge clk);
    @(posedge clk);
    hist_s[n] = v;
    hist_l[n] = v * 16;
    n++;
    @(negedge clk);
    es = ref_y(1'b0, n - 1 - DS);
    el = ref_y(1'b1, n - 1 - DL);
    chk(ov_s && ov_l, "R2 out_valid after accept", int'(ov_s), 1);
    chk(int'($signed(ys)) == es, "R2 short output", int'($signed(ys)), es);
    chk(int'($signed(yl)) == el, "R2 long output", int'($signed(yl)), el);
    last_s = int'($signed(ys));
    last_l = int'($signed(yl));
    if (last_s == 2047)  seen_max = 1;
    if (last_s == -2048) seen_min = 1;
  endtask

  task automatic flush(int cnt);
    for (int i = 0; i < cnt; i++) push(0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    @(negedge clk);
    chk(!ov_s && !ov_l, "R1 out_valid clear", int'(ov_s), 0);
    chk(ys == '0 && yl == '0, "R1 output zero", int'($signed(ys)), 0);
    chk(rdy_s && rdy_l, "R1 ready after reset", int'(rdy_s), 1);
  endtask

  task automatic t_impulse;
    push(1024);
    flush(DL + 4);
  endtask

  task automatic t_half_ties;
    push(-1024);   // R4: odd coefficients give exact -0.5 LSB ties
    flush(DL + 4);
    push(1024);
    push(-1024);
    flush(DL + 4);
  endtask

  task automatic t_random(int cnt);
    for (int i = 0; i < cnt; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) ? 32'h04C1_1DB7 : 0);
      push(int'($signed(12'(lfsr >>> 7))));
    end
  endtask

  task automatic t_saturate;
    seen_max = 0;
    seen_min = 0;
    for (int i = 0; i < 12; i++) push(TS[11 - i] >= 0 ? 2047 : -2047);
    flush(DS + 2);
    for (int i = 0; i < 12; i++) push(TS[11 - i] >= 0 ? -2048 : 2047);
    flush(DS + 2);
    for (int i = 0; i < 24; i++) push((i < 12 ? TL[11 - i] : TL[i - 12]) >= 0 ? 2047 : -2047);
    flush(DL + 2);
    chk(seen_max, "R5 short output clamped high", int'(seen_max), 1);
    chk(seen_min, "R5 short output clamped low", int'(seen_min), 1);
  endtask

  task automatic t_backpressure;
    t_random(8);
    out_ready = 1'b0;
    in_valid = 1'b1;
    xs = 12'h5A5;
    xl = 16'h5A50;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!rdy_s && !rdy_l, "R7 in_ready low while stalled", int'(rdy_s), 0);
      chk(ov_s && ov_l, "R7 out_valid held", int'(ov_s), 1);
      chk(int'($signed(ys)) == last_s, "R7 short output held", int'($signed(ys)), last_s);
      chk(int'($signed(yl)) == last_l, "R7 long output held", int'($signed(yl)), last_l);
    end
    chk(rdy_s == 1'b0, "R9 ready follows stall", int'(rdy_s), 0);
    out_ready = 1'b1;
    #1;
    chk(rdy_s && rdy_l, "R9 ready as soon as consumer ready", int'(rdy_s), 1);
    t_random(DL + 4);   // continuity proves the stalled value was ignored
  endtask

  task automatic t_idle;
    in_valid = 1'b0;
    xs = 12'h7FF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ov_s && !ov_l, "R8 out_valid drops when idle", int'(ov_s), 0);
      chk(int'($signed(ys)) == last_s, "R8 short output held", int'($signed(ys)), last_s);
      chk(rdy_s, "R9 ready while empty", int'(rdy_s), 1);
    end
    t_random(DL + 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_impulse();
    t_half_ties();
    t_random(60);
    t_backpressure();
    t_idle();
    t_saturate();
    t_random(20);
    do_reset();       // R1: history cleared, first results zero again
    t_random(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule